// File: doc/BRIEF.md
# Receive Line Idle and Character Timeout Detector

This block watches the serial receive line of a UART and measures how long it has stayed high, in whole bit periods. It keeps two independent counts. The sleep count drives an idle flag used to decide when the receiver may enter a low-power state. The timeout count drives a character-timeout request that tells software that data has been sitting in the receive FIFO with no further traffic.

The line level arrives already sampled at the centre of each bit. A one-cycle bit tick marks when that sample is valid. The idle threshold is a whole number of character frames: by default four frames of twelve bit periods each, so 48 bit periods. Both counts stop at the threshold instead of wrapping, so a long quiet spell gives one steady indication.

The two counts follow different rules. The sleep count is cleared only by line activity or by turning sleep mode off. The timeout count advances only while the FIFO holds data. It is also cleared by every read of received data and whenever the FIFO is empty.

Top module: `rx_idle_timer`

## Requirements
- R1: After rst_ni is released, idle_o and timeout_o are low and both counts are zero.
- R2: With sleep_en_i high, idle_o goes high in the cycle after the 48th consecutive tick on which rx_sample_i is high. It stays low after only 47 such ticks.
- R3: A tick with rx_sample_i low clears both counts. From the next cycle idle_o and timeout_o are low, and each needs a full 48 new high ticks to assert again.
- R4: rx_sample_i is used only in cycles where bit_tick_i is high. Cycles without a tick neither advance nor clear either count, whatever level rx_sample_i has.
- R5: The timeout count advances only on ticks while fifo_nempty_i is high. It is held at zero while fifo_nempty_i is low, and timeout_o is low in the cycle after fifo_nempty_i is seen low.
- R6: rd_strobe_i clears the timeout count, so timeout_o is low the next cycle. It has no effect on the sleep count or on idle_o.
- R7: Once asserted, timeout_o stays high until a read strobe, an empty FIFO or a low sample at a tick.
- R8: Both counts saturate at the threshold. Extra high ticks keep idle_o and timeout_o high and never wrap to zero.
- R9: While sleep_en_i is low the sleep count is held at zero, and idle_o is low from the cycle after sleep_en_i is seen low. The timeout count is unaffected by sleep_en_i.
- R10: The threshold equals FRAME_MULT times FRAME_BITS bit periods, 4 x 12 = 48 with default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit period; rx_sample_i is valid in this cycle |
| rx_sample_i | input | 1 | Receive line level sampled at mid-bit |
| fifo_nempty_i | input | 1 | Receive FIFO holds at least one character |
| rd_strobe_i | input | 1 | One-cycle pulse on each read of received data |
| sleep_en_i | input | 1 | Enables idle detection for sleep mode |
| idle_o | output | 1 | Line idle for the threshold while sleep mode is enabled |
| timeout_o | output | 1 | Character-timeout request |

## Verification
Every input is taken in by one register stage. Both outputs are decoded from those registers, so each result is due in the first cycle after the clock edge that captured the tick, read strobe, empty flag or sleep-enable change. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is exactly half a cycle after the edge that updates the counts. Counting tests space the ticks with tickless cycles, so an output that moved early or counted without a tick would be caught.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;
  // counter channel index
  localparam int unsigned CH_SLEEP = 0;
  localparam int unsigned CH_TMO   = 1;
  localparam int unsigned N_CH     = 2;

  typedef struct packed {
    logic clr;
    logic inc;
  } cnt_ctl_t;
endpackage

// File: rtl/rx_idle_ctl.sv
module rx_idle_ctl
  import rx_idle_pkg::*;
(
  input  logic     bit_tick_i,
  input  logic     rx_sample_i,
  input  logic     fifo_nempty_i,
  input  logic     rd_strobe_i,
  input  logic     sleep_en_i,
  output cnt_ctl_t ctl_o [N_CH]
);
  logic act, quiet;

  // activity = low level seen at a tick
  assign act   = bit_tick_i & ~rx_sample_i;
  assign quiet = bit_tick_i &  rx_sample_i;

  always_comb begin
    ctl_o[CH_SLEEP].clr = act | ~sleep_en_i;
    ctl_o[CH_SLEEP].inc = quiet & sleep_en_i;
    ctl_o[CH_TMO].clr   = act | rd_strobe_i | ~fifo_nempty_i;
    ctl_o[CH_TMO].inc   = quiet & fifo_nempty_i;
  end
endmodule

// File: rtl/rx_idle_sat_cnt.sv
module rx_idle_sat_cnt #(
  parameter int unsigned MAX   = 48,
  parameter int unsigned CNT_W = $clog2(MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != LIMIT) cnt_o <= cnt_o + CNT_W'(1);
  end

  assign full_o = (cnt_o == LIMIT);

  p_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LIMIT);
  p_hold_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clr_i |=> full_o);
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && !full_o |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  p_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(cnt_o));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rx_idle_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 12,
  parameter int unsigned FRAME_MULT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic rx_sample_i,
  input  logic fifo_nempty_i,
  input  logic rd_strobe_i,
  input  logic sleep_en_i,
  output logic idle_o,
  output logic timeout_o
);
  localparam int unsigned THRESH = FRAME_BITS * FRAME_MULT; // R10
  localparam int unsigned CNT_W  = $clog2(THRESH + 1);

  cnt_ctl_t         ctl  [N_CH];
  logic [CNT_W-1:0] cnt  [N_CH];
  logic [N_CH-1:0]  full;

  rx_idle_ctl u_ctl (
    .bit_tick_i    (bit_tick_i),
    .rx_sample_i   (rx_sample_i),
    .fifo_nempty_i (fifo_nempty_i),
    .rd_strobe_i   (rd_strobe_i),
    .sleep_en_i    (sleep_en_i),
    .ctl_o         (ctl)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    rx_idle_sat_cnt #(.MAX(THRESH), .CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (ctl[g].clr),
      .inc_i  (ctl[g].inc),
      .cnt_o  (cnt[g]),
      .full_o (full[g])
    );
  end

  assign idle_o    = full[CH_SLEEP];
  assign timeout_o = full[CH_TMO];

  p_rd_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> !timeout_o);
  p_empty_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_nempty_i |=> !timeout_o && cnt[CH_TMO] == '0);
  p_sleep_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_en_i |=> !idle_o && cnt[CH_SLEEP] == '0);
  p_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_i && !rx_sample_i |=> !idle_o && !timeout_o);
  p_to_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && fifo_nempty_i && !rd_strobe_i && !(bit_tick_i && !rx_sample_i)
      |=> timeout_o);
  p_rd_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && sleep_en_i && !(bit_tick_i && !rx_sample_i) |=> idle_o);
endmodule

// File: tb/sim_rx_idle_timer.sv
`timescale 1ns/1ps
module sim_rx_idle_timer;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0, rx = 1'b1, fifo = 1'b0, rd = 1'b0, slp = 1'b0;
  logic idle, tmo;
  int total = 0, bad = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rx_idle_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(tick), .rx_sample_i(rx),
    .fifo_nempty_i(fifo), .rd_strobe_i(rd), .sleep_en_i(slp),
    .idle_o(idle), .timeout_o(tmo)
  );

  // {n_high_ticks[7:0], fifo, sleep_en, exp_idle, exp_timeout}
  localparam int NV = 7;
  localparam logic [11:0] VEC [NV] = '{
    {8'd47, 4'b1100},
    {8'd48, 4'b1111},
    {8'd60, 4'b1111},
    {8'd48, 4'b0110},
    {8'd48, 4'b1001},
    {8'd10, 4'b1100},
    {8'd90, 4'b0000}
  };

  task automatic chk(input string req, input logic a_i, input logic a_t,
                     input logic e_i, input logic e_t);
    total++;
    if (a_i !== e_i || a_t !== e_t) begin
      bad++;
      $display("FAIL %s: idle=%b timeout=%b expected idle=%b timeout=%b",
               req, a_i, a_t, e_i, e_t);
    end
  endtask

  // one tick with level lvl, then a tickless cycle with line held at gap
  task automatic bit_tick(input logic lvl, input logic gap);
    @(negedge clk); tick = 1'b1; rx = lvl;
    @(negedge clk); tick = 1'b0; rx = gap;
  endtask

  task automatic ticks(input int n, input logic gap);
    for (int i = 0; i < n; i++) bit_tick(1'b1, gap);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset", idle, tmo, 1'b0, 1'b0);

    // table: clear with a low tick, then N high ticks
    for (int v = 0; v < NV; v++) begin
      fifo = VEC[v][3]; slp = VEC[v][2];
      bit_tick(1'b0, 1'b1);
      ticks(int'(VEC[v][11:4]), 1'b1);
      chk($sformatf("R2/R5/R8/R9/R10 vec%0d", v), idle, tmo, VEC[v][1], VEC[v][0]);
    end

    // R4: line low between ticks has no effect
    fifo = 1'b1; slp = 1'b1;
    bit_tick(1'b0, 1'b0);
    ticks(47, 1'b0);
    chk("R4 gap low, 47", idle, tmo, 1'b0, 1'b0);
    ticks(1, 1'b1);
    chk("R4 gap low, 48", idle, tmo, 1'b1, 1'b1);

    // R8: saturated, stays high every tick
    for (int i = 0; i < 20; i++) begin
      ticks(1, 1'b1);
      if (i % 5 == 0) chk("R8 saturated", idle, tmo, 1'b1, 1'b1);
    end

    // R7: hold without ticks
    repeat (10) @(negedge clk);
    chk("R7 hold", idle, tmo, 1'b1, 1'b1);

    // R6: read clears timeout only
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R6 read", idle, tmo, 1'b1, 1'b0);
    ticks(47, 1'b1);
    chk("R6 read restart 47", idle, tmo, 1'b1, 1'b0);
    ticks(1, 1'b1);
    chk("R6 read restart 48", idle, tmo, 1'b1, 1'b1);

    // R5: FIFO empties
    @(negedge clk); fifo = 1'b0;
    @(negedge clk);
    chk("R5 fifo empty", idle, tmo, 1'b1, 1'b0);
    ticks(60, 1'b1);
    fifo = 1'b1;
    ticks(1, 1'b1);
    chk("R5 no count while empty", idle, tmo, 1'b1, 1'b0);
    ticks(47, 1'b1);
    chk("R5 count after refill", idle, tmo, 1'b1, 1'b1);

    // R3: activity clears both
    bit_tick(1'b0, 1'b1);
    chk("R3 activity", idle, tmo, 1'b0, 1'b0);
    ticks(47, 1'b1);
    chk("R3 restart 47", idle, tmo, 1'b0, 1'b0);

    // R9: sleep off clears sleep count, timeout continues
    @(negedge clk); slp = 1'b0;
    @(negedge clk); slp = 1'b1;
    ticks(1, 1'b1);
    chk("R9 sleep toggle", idle, tmo, 1'b0, 1'b1);
    ticks(46, 1'b1);
    chk("R9 sleep 47", idle, tmo, 1'b0, 1'b1);
    ticks(1, 1'b1);
    chk("R9 sleep 48", idle, tmo, 1'b1, 1'b1);
    @(negedge clk); slp = 1'b0;
    @(negedge clk);
    chk("R9 sleep off", idle, tmo, 1'b0, 1'b1);

    // R1: async reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset again", idle, tmo, 1'b0, 1'b0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule